// File: doc/BRIEF.md
# Transmit Descriptor Fetch Engine

This block drives the transmit half of a descriptor-driven Ethernet DMA. Software builds a ring of descriptors in memory. Each descriptor holds a buffer pointer and a status word. Software then pulses a start input. The engine walks the ring from the queue base. For every descriptor it reads the status word and then the buffer pointer. It streams the buffer bytes one per cycle toward the MAC. Buffers are chained until one carries the end-of-frame flag.

When a frame finishes, the engine writes the status word of the frame's first descriptor back with its ownership (used) flag set. It then raises a sticky completion flag and moves on to the next descriptor. Processing stops at the first descriptor that is already marked used. If that happens part way through a frame, the frame is aborted and an exhaustion flag is written back. If transmission is disabled part way through a frame, the frame is aborted and an underrun flag is written back. Preamble, padding and CRC are the MAC's job.

Top module: `tx_desc_fetch`

## Requirements
- R1: When idle, a `tx_start` pulse with `tx_enable` high begins the walk by reading the status word of the descriptor at the queue base. A start while `tx_enable` is low, or while `busy` is high, has no effect. While idle the block makes no memory request and drives no byte.
- R2: A descriptor is 8 bytes. Word 0 holds the buffer byte address. Word 1 (byte offset 4) is the status word. Status bits: [10:0] length in bytes, [15] end of frame, [27] ran out of descriptors mid-frame, [28] underrun, [30] ring wrap, [31] used. The low 3 bits of `q_base` are ignored. Every memory write targets a status word.
- R3: The buffer bytes appear on `out_data` with `out_valid`, in address order, starting at any byte alignment. Byte k of a 32-bit memory word is bits [8k+7:8k]. A zero-length buffer emits no byte.
- R4: A descriptor with bit 31 set met at a frame boundary stops the engine. It returns to idle without any memory write.
- R5: After the last byte of a buffer with bit 15 set, the engine writes the first descriptor's status word with bit 31 set. When that write is acknowledged, `out_end` pulses for one cycle and `done_flag` sets.
- R6: After a descriptor with bit 30 set, the next descriptor is read from the queue base latched at start. Otherwise the next descriptor follows 8 bytes on.
- R7: A descriptor with bit 31 set met inside a frame aborts the frame. The engine writes the first descriptor's status word with bits 27 and 31 set, pulses `out_abort`, returns to idle and leaves `done_flag` unchanged.
- R8: If `tx_enable` is low when a descriptor status is read or a buffer word is about to be read, the engine acts on it. Outside a frame it simply stops. Inside a frame (including during the first buffer) it writes the first descriptor's status word with bits 28 and 31 set, pulses `out_abort` and returns to idle.
- R9: `done_flag` clears on a cycle with `done_clr` high, unless a completion sets it in that same cycle.
- R10: At most one memory access is outstanding at a time. `mem_req`, `mem_we` and `mem_addr` hold steady from the start of a request until the cycle that `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_enable | input | 1 | Transmit enable level |
| tx_start | input | 1 | Start pulse (write-1 of the start control bit) |
| q_base | input | AW | Transmit queue base address |
| done_clr | input | 1 | Write-1-to-clear of the completion flag |
| done_flag | output | 1 | Sticky frame-complete flag |
| busy | output | 1 | Engine is walking the ring |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| out_valid | output | 1 | A frame byte is on out_data |
| out_data | output | 8 | Frame byte |
| out_end | output | 1 | One-cycle pulse: frame completed |
| out_abort | output | 1 | One-cycle pulse: frame aborted |

## Verification
The underrun abort is the hardest case to reach from the ports. `tx_enable` must fall after a frame has started streaming, but before the engine asks for the next buffer word. The stimulus watches for the first `out_valid` and drops the enable on that same cycle. The buffer is word aligned and longer than four bytes, so the refill decision comes after the drop. A start pulse is also injected in the middle of a multi-descriptor walk, pointing at a different base. The final memory image must then match the walk from the original base only.

// File: rtl/txd_pkg.sv
`timescale 1ns/1ps
package txd_pkg;
   localparam int LAST_BIT = 15;
   localparam int EXH_BIT  = 27;
   localparam int UND_BIT  = 28;
   localparam int WRAP_BIT = 30;
   localparam int USED_BIT = 31;

   localparam logic [31:0] DONE_FLAGS = 32'h1 << USED_BIT;
   localparam logic [31:0] EXH_FLAGS  = (32'h1 << USED_BIT) | (32'h1 << EXH_BIT);
   localparam logic [31:0] UND_FLAGS  = (32'h1 << USED_BIT) | (32'h1 << UND_BIT);

   typedef enum logic [2:0] {
      S_IDLE,
      S_STAT,
      S_ADDR,
      S_DATA,
      S_WB,
      S_NEXT
   } txd_state_e;
endpackage

// File: rtl/txd_next_ptr.sv
`timescale 1ns/1ps
module txd_next_ptr #(
   parameter int AW         = 32,
   parameter int DESC_BYTES = 8
)(
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] base,
   input  logic          wrap,
   output logic [AW-1:0] nxt
);
   localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

   always_comb begin
      if (wrap) nxt = base;
      else      nxt = cur + STEP;
   end
endmodule

// File: rtl/txd_lane_pick.sv
`timescale 1ns/1ps
module txd_lane_pick #(
   parameter bit LITTLE_ENDIAN = 1'b1
)(
   input  logic [31:0] word,
   input  logic [1:0]  sel,
   output logic [7:0]  byte_o
);
   if (LITTLE_ENDIAN) begin : g_le
      always_comb begin
         unique case (sel)
            2'd0:    byte_o = word[7:0];
            2'd1:    byte_o = word[15:8];
            2'd2:    byte_o = word[23:16];
            default: byte_o = word[31:24];
         endcase
      end
   end else begin : g_be
      always_comb begin
         unique case (sel)
            2'd0:    byte_o = word[31:24];
            2'd1:    byte_o = word[23:16];
            2'd2:    byte_o = word[15:8];
            default: byte_o = word[7:0];
         endcase
      end
   end
endmodule

// File: rtl/txd_sticky_flag.sv
`timescale 1ns/1ps
module txd_sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !set |=> !q);
   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q);
endmodule

// File: rtl/tx_desc_fetch.sv
`timescale 1ns/1ps
module tx_desc_fetch
   import txd_pkg::*;
#(
   parameter int AW            = 32,
   parameter int LEN_W         = 11,
   parameter int DESC_BYTES    = 8,
   parameter bit LITTLE_ENDIAN = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tx_enable,
   input  logic          tx_start,
   input  logic [AW-1:0] q_base,
   input  logic          done_clr,
   output logic          done_flag,
   output logic          busy,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic [31:0]   mem_rdata,
   output logic          out_valid,
   output logic [7:0]    out_data,
   output logic          out_end,
   output logic          out_abort
);
   localparam int            DESC_LSB  = $clog2(DESC_BYTES);
   localparam logic [AW-1:0] BASE_MASK = ~AW'(DESC_BYTES - 1);
   localparam logic [AW-1:0] STAT_OFS  = AW'(4);

   if (AW < 12 || AW > 32) begin : g_bad_aw
      $error("tx_desc_fetch: AW must lie in 12..32");
   end
   if (LEN_W < 1 || LEN_W > 11) begin : g_bad_len
      $error("tx_desc_fetch: LEN_W must lie in 1..11");
   end
   if (DESC_BYTES < 8 || (1 << DESC_LSB) != DESC_BYTES) begin : g_bad_desc
      $error("tx_desc_fetch: DESC_BYTES must be a power of two of at least 8");
   end

   txd_state_e        st;
   logic [AW-1:0]     base_r, cur, first_addr, ptr, nxt;
   logic [31:0]       first_stat, cw, wb_flags;
   logic [AW-3:0]     cw_tag;
   logic [LEN_W-1:0]  rem;
   logic              last_r, wrap_r, in_frame, cw_ok, rd_pend, wb_done;
   logic              hit, done_set;
   logic [AW-1:0]     base_al;

   assign base_al = q_base & BASE_MASK;
   assign hit     = cw_ok && (cw_tag == ptr[AW-1:2]);
   assign busy    = (st != S_IDLE);

   txd_next_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_next (
      .cur(cur), .base(base_r), .wrap(wrap_r), .nxt(nxt)
   );

   txd_lane_pick #(.LITTLE_ENDIAN(LITTLE_ENDIAN)) u_lane (
      .word(cw), .sel(ptr[1:0]), .byte_o(out_data)
   );

   assign done_set = (st == S_WB) && mem_ack && wb_done;

   txd_sticky_flag u_done (
      .clk(clk), .rst_n(rst_n), .set(done_set), .clr(done_clr), .q(done_flag)
   );

   assign out_valid = (st == S_DATA) && (rem != '0) && hit;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = first_stat | wb_flags;
      unique case (st)
         S_STAT: begin mem_req = 1'b1; mem_addr = cur + STAT_OFS; end
         S_ADDR: begin mem_req = 1'b1; mem_addr = cur; end
         S_DATA: begin mem_req = rd_pend; mem_addr = {ptr[AW-1:2], 2'b00}; end
         S_WB:   begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = first_addr + STAT_OFS; end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         base_r     <= '0;
         cur        <= '0;
         first_addr <= '0;
         first_stat <= '0;
         ptr        <= '0;
         rem        <= '0;
         last_r     <= 1'b0;
         wrap_r     <= 1'b0;
         in_frame   <= 1'b0;
         cw         <= '0;
         cw_tag     <= '0;
         cw_ok      <= 1'b0;
         rd_pend    <= 1'b0;
         wb_flags   <= '0;
         wb_done    <= 1'b0;
         out_end    <= 1'b0;
         out_abort  <= 1'b0;
      end else begin
         out_end   <= 1'b0;
         out_abort <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (tx_start && tx_enable) begin
                  base_r   <= base_al;
                  cur      <= base_al;
                  in_frame <= 1'b0;
                  st       <= S_STAT;
               end
            end
            S_STAT: begin
               if (mem_ack) begin
                  rem    <= mem_rdata[LEN_W-1:0];
                  last_r <= mem_rdata[LAST_BIT];
                  wrap_r <= mem_rdata[WRAP_BIT];
                  if (mem_rdata[USED_BIT] || !tx_enable) begin
                     if (in_frame) begin
                        wb_flags <= mem_rdata[USED_BIT] ? EXH_FLAGS : UND_FLAGS;
                        wb_done  <= 1'b0;
                        st       <= S_WB;
                     end else begin
                        st <= S_IDLE;
                     end
                  end else begin
                     if (!in_frame) begin
                        first_addr <= cur;
                        first_stat <= mem_rdata;
                     end
                     st <= S_ADDR;
                  end
               end
            end
            S_ADDR: begin
               if (mem_ack) begin
                  ptr   <= mem_rdata[AW-1:0];
                  cw_ok <= 1'b0;
                  st    <= S_DATA;
               end
            end
            S_DATA: begin
               if (rem == '0) begin
                  if (last_r) begin
                     wb_flags <= DONE_FLAGS;
                     wb_done  <= 1'b1;
                     st       <= S_WB;
                  end else begin
                     in_frame <= 1'b1;
                     st       <= S_NEXT;
                  end
               end else if (hit) begin
                  ptr <= ptr + AW'(1);
                  rem <= rem - LEN_W'(1);
               end else if (rd_pend) begin
                  if (mem_ack) begin
                     cw      <= mem_rdata;
                     cw_tag  <= ptr[AW-1:2];
                     cw_ok   <= 1'b1;
                     rd_pend <= 1'b0;
                  end
               end else if (!tx_enable) begin
                  wb_flags <= UND_FLAGS;
                  wb_done  <= 1'b0;
                  st       <= S_WB;
               end else begin
                  rd_pend <= 1'b1;
               end
            end
            S_WB: begin
               if (mem_ack) begin
                  in_frame <= 1'b0;
                  if (wb_done) begin
                     out_end <= 1'b1;
                     st      <= S_NEXT;
                  end else begin
                     out_abort <= 1'b1;
                     st        <= S_IDLE;
                  end
               end
            end
            S_NEXT: begin
               cur <= nxt;
               st  <= S_STAT;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
   p_wr_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_addr[2:0] == 3'd4);
   p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req && !out_valid);
   p_emit_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !mem_req);
   p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_end && out_abort));
   p_abort_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_abort |-> !busy);
endmodule

// File: tb/sim_tx_desc_fetch.sv
`timescale 1ns/1ps
module sim_tx_desc_fetch;
   localparam logic [31:0] USED = 32'h8000_0000;
   localparam logic [31:0] WRAP = 32'h4000_0000;
   localparam logic [31:0] UND  = 32'h1000_0000;
   localparam logic [31:0] EXH  = 32'h0800_0000;
   localparam logic [31:0] LAST = 32'h0000_8000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        tx_enable = 1'b0, tx_start = 1'b0, done_clr = 1'b0;
   logic [31:0] q_base = '0;
   logic        done_flag, busy, mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        out_valid, out_end, out_abort;
   logic [7:0]  out_data;

   logic [31:0] mem [0:255];
   logic [31:0] ref_mem [0:255];
   logic [7:0]  exp_q [$];
   logic [7:0]  eb;
   int          lat = 0, wcnt = 0;
   bit          do_load = 1'b0, byte_chk_on = 1'b1;
   int          n_chk = 0, n_bad = 0;
   int          exp_end = 0, exp_abort = 0, got_end = 0, got_abort = 0, req_cyc = 0;

   always #2.5 clk = ~clk;

   tx_desc_fetch u0 (
      .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .tx_start(tx_start),
      .q_base(q_base), .done_clr(done_clr), .done_flag(done_flag), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid),
      .out_data(out_data), .out_end(out_end), .out_abort(out_abort)
   );

   // memory slave with programmable latency
   always @(posedge clk) begin
      if (do_load) begin
         for (int i = 0; i < 256; i++) mem[i] <= ref_mem[i];
      end
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
         wcnt      <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
         wcnt    <= 0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-clock comparison of the byte stream against the reference queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid && byte_chk_on) begin
            if (exp_q.size() == 0) chk(1'b0, "R3 unexpected byte", {24'h0, out_data}, 32'h0);
            else begin
               eb = exp_q.pop_front();
               chk(out_data == eb, "R3 byte order", {24'h0, out_data}, {24'h0, eb});
            end
         end
         if (out_end)   got_end++;
         if (out_abort) got_abort++;
         if (mem_req)   req_cyc++;
      end
   end

   task automatic put_desc(input int a, input logic [31:0] buf_a, input logic [31:0] stat);
      ref_mem[a >> 2]       = buf_a;
      ref_mem[(a >> 2) + 1] = stat;
   endtask

   task automatic model_walk(input int base);
      int cur = base, first = 0, p = 0;
      bit infr = 1'b0;
      logic [31:0] st, fst = '0, a, w;
      for (int g = 0; g < 64; g++) begin
         st = ref_mem[(cur + 4) >> 2];
         if (st[31]) begin
            if (infr) begin
               ref_mem[(first + 4) >> 2] = fst | EXH | USED;
               exp_abort++;
            end
            return;
         end
         if (!infr) begin first = cur; fst = st; end
         a = ref_mem[cur >> 2];
         for (int i = 0; i < int'(st[10:0]); i++) begin
            p = int'(a) + i;
            w = ref_mem[p >> 2];
            exp_q.push_back(w[8*(p % 4) +: 8]);
         end
         if (st[15]) begin
            ref_mem[(first + 4) >> 2] = fst | USED;
            exp_end++;
            infr = 1'b0;
         end else infr = 1'b1;
         cur = st[30] ? base : cur + 8;
      end
   endtask

   task automatic load_mem();
      do_load = 1'b1;
      @(negedge clk);
      do_load = 1'b0;
      exp_end = 0; exp_abort = 0; got_end = 0; got_abort = 0;
   endtask

   task automatic wait_idle(input string req);
      for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
      repeat (2) @(negedge clk);
      chk(!busy, req, {31'h0, busy}, 32'h0);
   endtask

   task automatic compare_all(input string req);
      int bad = 0, fb = -1;
      for (int i = 0; i < 256; i++)
         if (mem[i] !== ref_mem[i]) begin bad++; if (fb < 0) fb = i; end
      chk(bad == 0, req, (fb < 0) ? 32'h0 : mem[fb], (fb < 0) ? 32'h0 : ref_mem[fb]);
   endtask

   task automatic run(input int base, input int latency, input bit spurious, input string req);
      lat = latency;
      load_mem();
      model_walk(base);
      done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
      q_base = base; tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
      if (spurious) begin
         repeat (6) @(negedge clk);
         q_base = 32'h80; tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
      end
      wait_idle(req);
      compare_all(req);
      chk(exp_q.size() == 0, {req, " bytes left"}, exp_q.size(), 0);
      chk(got_end == exp_end, {req, " end pulses"}, got_end, exp_end);
      chk(got_abort == exp_abort, {req, " abort pulses"}, got_abort, exp_abort);
      chk(done_flag == (exp_end > 0), "R5 done flag", {31'h0, done_flag}, {31'h0, exp_end > 0});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++)
         ref_mem[i] = (i < 64) ? 32'h0 : (32'hA55A_0F00 ^ (i * 32'h0103_0507));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done_flag && !out_valid && !mem_req, "R1 reset state",
          {28'h0, busy, done_flag, out_valid, mem_req}, 32'h0);
      tx_enable = 1'b1;

      // R5 single-buffer frame, then R4 halt on used descriptor
      put_desc(32'h00, 32'h100, LAST | 32'd5);
      put_desc(32'h08, 32'h0, USED);
      run(32'h00, 0, 1'b0, "R5 single frame");

      // R9 clear of the completion flag
      done_clr = 1'b1; @(negedge clk); done_clr = 1'b0; @(negedge clk);
      chk(!done_flag, "R9 clear", {31'h0, done_flag}, 32'h0);

      // R3 unaligned chained buffers, R6 wrap back to base, R1 start while busy ignored
      put_desc(32'h40, 32'h203, 32'd7);
      put_desc(32'h48, 32'h150, 32'd0);
      put_desc(32'h50, 32'h181, LAST | 32'd6);
      put_desc(32'h58, 32'h1F0, LAST | WRAP | 32'd3);
      run(32'h40, 2, 1'b1, "R6 ring wrap");
      chk(got_end == 2, "R1 start while busy", got_end, 2);

      // R4 used descriptor at the base: no write, nothing sent
      put_desc(32'h80, 32'h100, USED | LAST | 32'd4);
      run(32'h80, 1, 1'b0, "R4 halt");

      // R7 descriptors exhausted mid-frame
      put_desc(32'hA0, 32'h102, 32'd4);
      put_desc(32'hA8, 32'h0, USED);
      run(32'hA0, 1, 1'b0, "R7 exhausted");

      // R8 transmit disabled mid-frame
      put_desc(32'hC0, 32'h300, 32'd8);
      put_desc(32'hC8, 32'h310, LAST | 32'd4);
      lat = 1;
      load_mem();
      byte_chk_on = 1'b0;
      q_base = 32'hC0; tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
      for (int i = 0; i < 200 && !out_valid; i++) @(negedge clk);
      tx_enable = 1'b0;
      wait_idle("R8 underrun idle");
      ref_mem[32'hC4 >> 2] = ref_mem[32'hC4 >> 2] | UND | USED;
      compare_all("R8 underrun status");
      chk(got_abort == 1 && got_end == 0, "R8 abort pulse", got_abort, 1);
      byte_chk_on = 1'b1;

      // R1 start with transmission disabled
      req_cyc = 0;
      q_base = 32'h00; tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
      repeat (8) @(negedge clk);
      chk(!busy && req_cyc == 0, "R1 start while disabled", req_cyc, 0);
      tx_enable = 1'b1;

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule